// File: doc/BRIEF.md
# Quasi-Resonant Switching Period Controller

This block times the power switch of a quasi-resonant converter. It decides, clock by clock, when each gate-drive pulse begins and when it ends. A new pulse normally begins on a qualified valley pulse from the drain-voltage detector. Three rules govern the start of a pulse. A blanking window after each rising edge sets the minimum switching period. A late trigger covers the case where valleys came only inside that window. A starter timeout covers the case where no valley comes at all.

Each pulse lasts the requested on-time, clamped to a fixed minimum and maximum. A peak-current-limit flag can end the pulse early, but only after a short leading-edge blanking interval and never before the minimum on-time. A protection enable stops the gate at once and clears all timing. After enable returns, the first pulse always comes from the starter.

All intervals are parameters in clock cycles. Every period interval is measured from the rising edge of the previous gate pulse.

Top module: `qr_period_ctrl`

## Requirements
- R1: While reset is asserted, `gate_o` and `cyc_start_o` are low.
- R2: Let cycle 0 be the first cycle of a gate pulse. If the gate is low in cycle k, k is at least MIN_PERIOD_CYC, and `valley_i` is high, the next pulse rises one clock later, giving a period of k+1 cycles.
- R3: A valley in any cycle k below MIN_PERIOD_CYC never starts a pulse.
- R4: If a valley was seen with the gate low and k below MIN_PERIOD_CYC, and no valley follows, the next pulse starts with a period of MIN_PERIOD_CYC+LATE_EXTRA_CYC+1 cycles.
- R5: With no valley at all, the next pulse starts with a period of STARTER_CYC+1 cycles.
- R6: Valleys that arrive while the gate is high are disregarded. The period then falls back to the starter value.
- R7: Without current limit, the pulse lasts clamp(`on_req_i`, MIN_ON_CYC, MAX_ON_CYC) cycles. The request is taken in the cycle before the rising edge.
- R8: When `cur_lim_i` is high in pulse cycle c, the pulse ends after cycle c, giving a width of c+1. This only applies when c is at least CL_BLANK_CYC and at least MIN_ON_CYC-1. The width never exceeds the clamped target.
- R9: A current-limit flag that is high only within the first CL_BLANK_CYC cycles of a pulse leaves the pulse width unchanged.
- R10: With `en_i` low, `gate_o` goes low in the same cycle and all timers clear. Once `en_i` is high again, the first pulse rises STARTER_CYC+1 cycles later, whatever valleys arrive meanwhile. The same holds after reset.
- R11: `cyc_start_o` is high for exactly one cycle, which is the first cycle of every gate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Run enable from the protection logic |
| valley_i | input | 1 | Qualified valley pulse |
| cur_lim_i | input | 1 | Peak-current-limit flag |
| on_req_i | input | REQ_W | Requested on-time in clock cycles |
| gate_o | output | 1 | Gate-drive enable |
| cyc_start_o | output | 1 | One-cycle strobe at each gate rising edge |

## Verification
The bench builds the block with a 20-cycle minimum period, an 8-cycle late extension and a 60-cycle starter. The on-time limits are 4 and 30 cycles, with a 5-cycle blanking interval and an 8-bit request. With these values, every trigger path completes in a few dozen cycles. Requests below the minimum and above the maximum are reachable. Because the blanking interval is longer than the minimum on-time less one, the blanking rule is observable on its own. Random valley placements and current-limit windows are mixed with directed cases at each threshold.

// File: rtl/qrp_pkg.sv
package qrp_pkg;

  // Which condition launched a new gate pulse
  typedef enum logic [1:0] {
    TRIG_NONE    = 2'd0,
    TRIG_VALLEY  = 2'd1,
    TRIG_LATE    = 2'd2,
    TRIG_STARTER = 2'd3
  } trig_e;

endpackage

// File: rtl/qrp_ontime_clamp.sv
module qrp_ontime_clamp #(
  parameter int REQ_W  = 12,
  parameter int ON_W   = 12,
  parameter int MIN_ON = 135,
  parameter int MAX_ON = 3250
) (
  input  logic [REQ_W-1:0] req_i,
  output logic [ON_W-1:0]  tgt_o
);

  localparam longint REQ_TOP = (64'd1 << REQ_W) - 64'd1;

  logic [31:0] req_ext;
  assign req_ext = 32'(req_i);

  generate
    if (REQ_TOP > MAX_ON) begin : g_upper
      // Request range can exceed the ceiling: clamp on both sides
      always_comb begin
        if (req_ext < 32'(MIN_ON))      tgt_o = ON_W'(MIN_ON);
        else if (req_ext > 32'(MAX_ON)) tgt_o = ON_W'(MAX_ON);
        else                            tgt_o = ON_W'(req_ext);
      end
    end else begin : g_lower_only
      // Request range cannot exceed the ceiling: floor only
      always_comb begin
        if (req_ext < 32'(MIN_ON)) tgt_o = ON_W'(MIN_ON);
        else                       tgt_o = ON_W'(req_ext);
      end
    end
  endgenerate

endmodule

// File: rtl/qrp_period_timer.sv
module qrp_period_timer
  import qrp_pkg::*;
#(
  parameter int MIN_P = 425,
  parameter int EXTRA = 250,
  parameter int START = 3750
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  gate_i,
  input  logic  valley_i,
  output trig_e trig_o
);

  localparam int CNT_W = $clog2(START + 1);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_P);
  localparam logic [CNT_W-1:0] LATE_C  = CNT_W'(MIN_P + EXTRA);
  localparam logic [CNT_W-1:0] START_C = CNT_W'(START);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             seen_q, seen_d;   // valley seen inside the blanking window
  logic             first_q, first_d; // next pulse must come from the starter
  trig_e            trig;

  // Trigger decision, gate must be low
  always_comb begin
    trig = TRIG_NONE;
    if (en_i && !gate_i) begin
      if (!first_q && valley_i && (cnt_q >= MIN_C))     trig = TRIG_VALLEY;
      else if (!first_q && seen_q && (cnt_q >= LATE_C)) trig = TRIG_LATE;
      else if (cnt_q >= START_C)                        trig = TRIG_STARTER;
    end
  end

  assign trig_o = trig;

  // Next state
  always_comb begin
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    seen_d  = seen_q;
    first_d = first_q;
    if (!en_i) begin
      cnt_d   = '0;
      cnt_en  = 1'b1;
      seen_d  = 1'b0;
      first_d = 1'b1;
    end else if (trig != TRIG_NONE) begin
      cnt_d   = '0;
      cnt_en  = 1'b1;
      seen_d  = 1'b0;
      first_d = 1'b0;
    end else begin
      if (cnt_q != START_C) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
      if (valley_i && !gate_i && !first_q && (cnt_q < MIN_C)) seen_d = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      first_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      seen_q  <= seen_d;
      first_q <= first_d;
    end
  end

  // R3: a valley inside the blanking window never launches a pulse
  p_valley_blank_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && valley_i && (cnt_q < MIN_C)) |=> !$rose(gate_i));

  // R4: blanking-only valley forces a pulse at the late threshold
  p_late_fire_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !gate_i && !first_q && seen_q && (cnt_q >= LATE_C)) |=> gate_i);

  // R5: the starter always launches at its limit
  p_starter_fire_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !gate_i && (cnt_q >= START_C)) |=> gate_i);

endmodule

// File: rtl/qrp_on_timer.sv
module qrp_on_timer #(
  parameter int MIN_ON = 135,
  parameter int MAX_ON = 3250,
  parameter int BLANK  = 20,
  parameter int REQ_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [REQ_W-1:0] req_i,
  input  logic             cl_i,
  output logic             gate_o
);

  localparam int CL_FROM = (BLANK > MIN_ON - 1) ? BLANK : MIN_ON - 1;
  localparam int CNT_TOP = (MAX_ON > CL_FROM) ? MAX_ON : CL_FROM;
  localparam int ON_W    = $clog2(CNT_TOP + 1);
  localparam logic [ON_W-1:0] CL_C  = ON_W'(CL_FROM);
  localparam logic [ON_W-1:0] MINM1 = ON_W'(MIN_ON - 1);
  localparam logic [ON_W-1:0] MAX_C = ON_W'(MAX_ON);

  logic [ON_W-1:0] tgt_new, tgt_q, tgt_d;
  logic            tgt_en;
  logic [ON_W-1:0] on_cnt_q, on_cnt_d;
  logic            gate_q, gate_d;
  logic            reach_tgt, cl_cut, turn_off;

  qrp_ontime_clamp #(
    .REQ_W  (REQ_W),
    .ON_W   (ON_W),
    .MIN_ON (MIN_ON),
    .MAX_ON (MAX_ON)
  ) u_clamp (
    .req_i (req_i),
    .tgt_o (tgt_new)
  );

  // End-of-pulse conditions
  always_comb begin
    reach_tgt = (({1'b0, on_cnt_q} + 1'b1) >= {1'b0, tgt_q});
    cl_cut    = cl_i && (on_cnt_q >= CL_C);
    turn_off  = reach_tgt || cl_cut;
  end

  // Next state
  always_comb begin
    gate_d   = gate_q;
    on_cnt_d = on_cnt_q;
    tgt_d    = tgt_q;
    tgt_en   = 1'b0;
    if (!en_i) begin
      gate_d   = 1'b0;
      on_cnt_d = '0;
    end else if (start_i) begin
      gate_d   = 1'b1;
      on_cnt_d = '0;
      tgt_d    = tgt_new;
      tgt_en   = 1'b1;
    end else if (gate_q) begin
      if (turn_off) begin
        gate_d   = 1'b0;
        on_cnt_d = '0;
      end else begin
        on_cnt_d = on_cnt_q + 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      on_cnt_q <= '0;
      tgt_q    <= '0;
    end else begin
      gate_q   <= gate_d;
      on_cnt_q <= on_cnt_d;
      if (tgt_en) tgt_q <= tgt_d;
    end
  end

  assign gate_o = gate_q;

  // R7 / R8: every pulse ended by its own timing lies within the on-time limits
  p_on_bounds_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_q) && $past(en_i)) |->
      (($past(on_cnt_q) >= MINM1) && ($past(on_cnt_q) < MAX_C)));

  // R10: a low enable clears the registered gate on the next edge
  p_drop_gate_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !gate_q);

endmodule

// File: rtl/qr_period_ctrl.sv
module qr_period_ctrl
  import qrp_pkg::*;
#(
  parameter int MIN_PERIOD_CYC = 425,
  parameter int LATE_EXTRA_CYC = 250,
  parameter int STARTER_CYC    = 3750,
  parameter int MIN_ON_CYC     = 135,
  parameter int MAX_ON_CYC     = 3250,
  parameter int CL_BLANK_CYC   = 20,
  parameter int REQ_W          = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             valley_i,
  input  logic             cur_lim_i,
  input  logic [REQ_W-1:0] on_req_i,
  output logic             gate_o,
  output logic             cyc_start_o
);

  trig_e trig;
  logic  start;
  logic  gate_q;
  logic  strobe_q, strobe_d;

  qrp_period_timer #(
    .MIN_P (MIN_PERIOD_CYC),
    .EXTRA (LATE_EXTRA_CYC),
    .START (STARTER_CYC)
  ) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .gate_i   (gate_q),
    .valley_i (valley_i),
    .trig_o   (trig)
  );

  assign start = (trig != TRIG_NONE);

  qrp_on_timer #(
    .MIN_ON (MIN_ON_CYC),
    .MAX_ON (MAX_ON_CYC),
    .BLANK  (CL_BLANK_CYC),
    .REQ_W  (REQ_W)
  ) u_ontime (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .start_i (start),
    .req_i   (on_req_i),
    .cl_i    (cur_lim_i),
    .gate_o  (gate_q)
  );

  always_comb strobe_d = start && en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  // Enable acts on the outputs without waiting for a clock edge
  assign gate_o      = gate_q && en_i;
  assign cyc_start_o = strobe_q && en_i;

  // R11: the strobe marks each rising edge of the gate
  p_strobe_at_rise_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> strobe_q);

  // R11: the strobe never lasts more than one cycle
  p_strobe_one_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

endmodule

// File: tb/qr_period_ctrl_bench.sv
module qr_period_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int P_MIN   = 20;
  localparam int P_EXTRA = 8;
  localparam int P_START = 60;
  localparam int P_MINON = 4;
  localparam int P_MAXON = 30;
  localparam int P_BLANK = 5;
  localparam int P_REQW  = 8;

  logic clk = 1'b0;
  logic rst_n, en, valley, cur_lim;
  logic [P_REQW-1:0] req;
  logic gate_o, cyc_start_o;

  int n_chk = 0;
  int n_fail = 0;
  int cur_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  qr_period_ctrl #(
    .MIN_PERIOD_CYC (P_MIN),
    .LATE_EXTRA_CYC (P_EXTRA),
    .STARTER_CYC    (P_START),
    .MIN_ON_CYC     (P_MINON),
    .MAX_ON_CYC     (P_MAXON),
    .CL_BLANK_CYC   (P_BLANK),
    .REQ_W          (P_REQW)
  ) u_qr_period_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .valley_i    (valley),
    .cur_lim_i   (cur_lim),
    .on_req_i    (req),
    .gate_o      (gate_o),
    .cyc_start_o (cyc_start_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp_on(input int r);
    if (r < P_MINON) return P_MINON;
    if (r > P_MAXON) return P_MAXON;
    return r;
  endfunction

  // Pulse width from the request and a current-limit window [clc, cle]
  function automatic int exp_width(input int r, input int clc, input int cle);
    int t = clamp_on(r);
    for (int k = 0; k < t; k++)
      if (clc >= 0 && k >= clc && k <= cle && k >= P_BLANK && k >= P_MINON - 1)
        return k + 1;
    return t;
  endfunction

  // Period from an early valley e and a later valley l (-1 = none)
  function automatic int exp_period(input int e, input int l, input int w);
    bit early_ok = (e >= 0) && (e >= w) && (e < P_MIN);
    if (early_ok)
      return (l >= P_MIN && l <= P_MIN + P_EXTRA) ? l + 1 : P_MIN + P_EXTRA + 1;
    return (l >= P_MIN && l <= P_START) ? l + 1 : P_START + 1;
  endfunction

  // Called at the negedge in pulse cycle 0; returns at the next cycle 0
  task automatic run_period(input string tag, input int nreq, input int clc,
                            input int cle, input int e, input int l);
    int w_obs = 0;
    int p = -1;
    int ew, ep;
    ew = exp_width(cur_req, clc, cle);
    ep = exp_period(e, l, ew);
    chk({tag, " R11 strobe at rise"}, int'(cyc_start_o), 1);
    req = P_REQW'(nreq);
    for (int k = 0; k <= P_START + 10; k++) begin
      if (k > 0) @(negedge clk);
      if (k > 0 && cyc_start_o) begin
        p = k;
        break;
      end
      if (gate_o) w_obs++;
      cur_lim = (clc >= 0 && k >= clc && k <= cle);
      valley  = (k == e) || (k == l);
    end
    cur_lim = 1'b0;
    valley  = 1'b0;
    chk({tag, " width"}, w_obs, ew);
    chk({tag, " period"}, p, ep);
    cur_req = nreq;
  endtask

  // Counts negedges until a strobe, driving one valley at index vk
  task automatic count_to_strobe(input int vk, output int n);
    n = -1;
    for (int k = 0; k <= P_START + 10; k++) begin
      if (k > 0) @(negedge clk);
      if (k > 0 && cyc_start_o) begin
        n = k;
        break;
      end
      valley = (k == vk);
    end
    valley = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b1; valley = 1'b0; cur_lim = 1'b0;
    req = P_REQW'(10); cur_req = 10;
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", int'(gate_o), 0);
    chk("R1 strobe in reset", int'(cyc_start_o), 0);
    rst_n = 1'b1;
    // R10: first pulse after reset comes from the starter, valley ignored
    count_to_strobe(25, n);
    chk("R10 first pulse after reset", n, P_START + 1);

    run_period("R2 valley after window", 10, -1, -1, -1, 25);
    run_period("R4 late trigger", 10, -1, -1, 12, -1);
    run_period("R3 early valley only", 10, -1, -1, 15, -1);
    run_period("R5 starter", 10, -1, -1, -1, -1);
    run_period("R6 valley while gate high", 10, -1, -1, 5, -1);
    run_period("R2 early then late valley", 10, -1, -1, 12, 22);
    run_period("R2 valley at window edge", 2, -1, -1, -1, P_MIN);
    run_period("R7 clamp low", 50, -1, -1, -1, 30);
    run_period("R7 clamp high", 10, -1, -1, -1, 40);
    run_period("R8 limit held from start", 10, 0, 100, -1, 25);
    run_period("R8 limit from cycle 7", 10, 7, 100, -1, 25);
    run_period("R9 limit inside blanking", 10, 3, 4, -1, 25);
    run_period("R4 late boundary valley", 10, -1, -1, 14, P_MIN + P_EXTRA);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int nr, mode, clc, cle, w, e, l;
      nr   = int'($urandom_range(0, 40));
      mode = int'($urandom_range(0, 3));
      clc  = -1; cle = -1;
      if ($urandom_range(0, 1) == 1) begin
        clc = int'($urandom_range(0, 35));
        cle = clc + int'($urandom_range(0, 40));
      end
      w = exp_width(cur_req, clc, cle);
      e = -1; l = -1;
      if ((mode == 1 || mode == 3) && w < P_MIN)
        e = int'($urandom_range(w, P_MIN - 1));
      if (mode == 2 || mode == 3)
        l = int'($urandom_range((w > P_MIN) ? w : P_MIN, 58));
      run_period("R2 R7 random", nr, clc, cle, e, l);
    end

    // R10: enable drop mid-pulse, then starter-only restart
    chk("R11 strobe before drop", int'(cyc_start_o), 1);
    repeat (2) @(negedge clk);
    en = 1'b0;
    #1;
    chk("R10 gate drops with enable", int'(gate_o), 0);
    repeat (4) begin
      @(negedge clk);
      chk("R10 gate held low", int'(gate_o), 0);
    end
    en = 1'b1;
    count_to_strobe(30, n);
    chk("R10 restart through starter", n, P_START + 1);
    run_period("R2 after restart", 10, -1, -1, -1, 33);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule